// File: doc/BRIEF.md
# PCIe Slot Hotplug Event Controller

This block holds the hotplug slice of a PCIe downstream port's capability registers: Slot Capabilities, Slot Control, Slot Status, and the Data Link Layer Link Active flag in Link Status. A management agent announces that a device was inserted or pulled with single-cycle `evt_add` and `evt_remove` pulses. The block then updates presence and link state in one step and latches the two changed flags. When software has enabled it, the block also asks for an MSI.

Software reaches the registers through a plain dword config port with byte enables. The changed flags are write-1-to-clear. Slot Control writes take effect at once. The block reports that it has no command-completion mechanism, so a Slot Control write never leads to a completion interrupt. If software turns on the hotplug interrupt while an enabled event is still unacknowledged, the block issues one catch-up MSI request.

The capability starts at byte offset `CAP_BASE`. Link Status is the upper half of the dword at `CAP_BASE+0x10`. Slot Capabilities is the dword at `CAP_BASE+0x14`. Slot Control is the lower half and Slot Status the upper half of the dword at `CAP_BASE+0x18`. `cfg_addr` is a dword index, so it equals the byte offset divided by 4.

Top module: `slot_hp_ctrl`

## Requirements
- R1: An accepted add event sets presence state (dword bit 22 at +0x18) and link active (dword bit 29 at +0x10). It also sets presence-changed (bit 19) and link-state-changed (bit 24). All four are visible on the next read.
- R2: An accepted remove event clears presence state and link active, and sets both changed bits.
- R3: `msi_req` is high for exactly one cycle, in the cycle right after the clock edge that samples an accepted event. This happens only if hotplug interrupt enable (bit 5) is 1 and at least one of presence-changed enable (bit 3) or link-state-changed enable (bit 12) is 1.
- R4: Writing 1 to bit 19 with byte enable 2, or to bit 24 with byte enable 3, clears that changed bit. Writing 0, or writing with that byte enable low, leaves it unchanged.
- R5: When an event and a clear of a changed bit land in the same cycle, the changed bit stays 1.
- R6: Slot Capabilities reads back as follows: no-command-completed (bit 18) = 1, hotplug capable (bit 6) = 1, surprise removal (bit 5) = 1, and `SLOT_NUM` in bits [31:19]. All other bits are 0.
- R7: Only Slot Control bits 3, 4, 5 and 12 store a value. Byte lane 0 writes bits 3 to 5 and byte lane 1 writes bit 12. The new value takes effect on the edge of the write. Command-completed (bit 20) always reads 0.
- R8: Software writes to presence state (bit 22) and link active (bit 29) have no effect.
- R9: When hotplug interrupt enable goes from 0 to 1 while a changed bit whose own enable is 1 is still set, exactly one `msi_req` pulse appears. It comes in the second cycle after the write edge. No pulse appears if no enabled changed bit is pending, or if the interrupt enable was already 1.
- R10: An add event while occupied, a remove event while empty, or add and remove together have no effect on state and produce no MSI request.
- R11: After reset, Slot Control is 0, the slot is empty, all status bits are 0 and `msi_req` is 0. `cfg_rdata` is updated at the edge that samples `cfg_rd_en`, and unmapped dwords read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Config write strobe |
| cfg_rd_en | input | 1 | Config read strobe |
| cfg_addr | input | ADDR_W | Dword index of the access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| evt_add | input | 1 | Device inserted pulse |
| evt_remove | input | 1 | Device removed pulse |
| msi_req | output | 1 | One-cycle MSI request |

## Verification
Two functions can meet in one cycle. The first pair is a management event and a software write-1-to-clear of the changed bits. The bench drives both in the same clock and then reads Slot Status back to confirm that the event's setting of the bits wins. The second pair is a late interrupt enable and a still-pending event. The bench raises the enable after an unacknowledged event and expects a single pulse exactly two cycles after the write. A sweep over all 16 enable combinations, both starting occupancies and all four event patterns computes the expected MSI and status in arithmetic and checks every case.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  // bit positions inside the 32-bit dwords seen by software
  localparam int SC_PDCE   = 3;
  localparam int SC_CCIE   = 4;
  localparam int SC_HPIE   = 5;
  localparam int SC_DLLSCE = 12;
  localparam int ST_PDC    = 19;
  localparam int ST_CC     = 20;
  localparam int ST_PDS    = 22;
  localparam int ST_DLLSC  = 24;
  localparam int LS_DLLLA  = 29;
  localparam int CAP_HPS   = 5;
  localparam int CAP_HPC   = 6;
  localparam int CAP_NCCS  = 18;
  localparam int CAP_PSN   = 19;

  typedef struct packed {
    logic dll_en;   // link-state-changed enable
    logic hp_ie;    // hotplug interrupt enable
    logic cc_ie;    // completion interrupt enable (stored only)
    logic pres_en;  // presence-changed enable
  } slot_ctl_t;

  typedef struct packed {
    logic present;
    logic link_up;
    logic pres_chg;
    logic link_chg;
  } slot_st_t;
endpackage

// File: rtl/slot_hp_cfg.sv
module slot_hp_cfg
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CAP_BASE = 'h40,
  parameter int SLOT_NUM = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  input  slot_st_t          st,
  output slot_ctl_t         ctl,
  output logic              clr_pres_chg,
  output logic              clr_link_chg,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] LNK_IDX = ADDR_W'((CAP_BASE + 16) / 4);
  localparam logic [ADDR_W-1:0] CAP_IDX = ADDR_W'((CAP_BASE + 20) / 4);
  localparam logic [ADDR_W-1:0] CTL_IDX = ADDR_W'((CAP_BASE + 24) / 4);

  logic hit_ctl, hit_cap, hit_lnk;
  logic [31:0] cap_word, ctl_word, lnk_word, rd_mux;
  slot_ctl_t ctl_q;

  assign hit_ctl = (addr == CTL_IDX);
  assign hit_cap = (addr == CAP_IDX);
  assign hit_lnk = (addr == LNK_IDX);

  assign clr_pres_chg = wr_en & hit_ctl & be[ST_PDC/8]   & wdata[ST_PDC];
  assign clr_link_chg = wr_en & hit_ctl & be[ST_DLLSC/8] & wdata[ST_DLLSC];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en && hit_ctl) begin
      if (be[0]) begin
        ctl_q.pres_en <= wdata[SC_PDCE];
        ctl_q.cc_ie   <= wdata[SC_CCIE];
        ctl_q.hp_ie   <= wdata[SC_HPIE];
      end
      if (be[1]) begin
        ctl_q.dll_en  <= wdata[SC_DLLSCE];
      end
    end
  end
  assign ctl = ctl_q;

  always_comb begin
    cap_word = '0;
    cap_word[CAP_HPS]  = 1'b1;
    cap_word[CAP_HPC]  = 1'b1;
    cap_word[CAP_NCCS] = 1'b1;
    cap_word[31:CAP_PSN] = 13'(SLOT_NUM);

    ctl_word = '0;
    ctl_word[SC_PDCE]   = ctl_q.pres_en;
    ctl_word[SC_CCIE]   = ctl_q.cc_ie;
    ctl_word[SC_HPIE]   = ctl_q.hp_ie;
    ctl_word[SC_DLLSCE] = ctl_q.dll_en;
    ctl_word[ST_PDC]    = st.pres_chg;
    ctl_word[ST_CC]     = 1'b0;
    ctl_word[ST_PDS]    = st.present;
    ctl_word[ST_DLLSC]  = st.link_chg;

    lnk_word = '0;
    lnk_word[LS_DLLLA]  = st.link_up;

    if (hit_cap)      rd_mux = cap_word;
    else if (hit_ctl) rd_mux = ctl_word;
    else if (hit_lnk) rd_mux = lnk_word;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_ctl) |=> $stable(ctl_q));
endmodule

// File: rtl/slot_hp_state.sv
module slot_hp_state
  import slot_hp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     evt_add,
  input  logic     evt_remove,
  input  logic     clr_pres_chg,
  input  logic     clr_link_chg,
  output slot_st_t st,
  output logic     ev_ok
);
  logic add_ok, rem_ok;
  slot_st_t st_q;

  assign add_ok = evt_add & ~evt_remove & ~st_q.present;
  assign rem_ok = evt_remove & ~evt_add & st_q.present;
  assign ev_ok  = add_ok | rem_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (add_ok) begin
        st_q.present <= 1'b1;
        st_q.link_up <= 1'b1;
      end else if (rem_ok) begin
        st_q.present <= 1'b0;
        st_q.link_up <= 1'b0;
      end
      // an event in the same cycle overrides a software clear
      st_q.pres_chg <= ev_ok | (st_q.pres_chg & ~clr_pres_chg);
      st_q.link_chg <= ev_ok | (st_q.link_chg & ~clr_link_chg);
    end
  end
  assign st = st_q;

  p_add_sets_r1: assert property (@(posedge clk) disable iff (rst)
    add_ok |=> (st_q.present && st_q.link_up && st_q.pres_chg && st_q.link_chg));
  p_rem_clears_r2: assert property (@(posedge clk) disable iff (rst)
    rem_ok |=> (!st_q.present && !st_q.link_up && st_q.pres_chg && st_q.link_chg));
  p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_pres_chg && !evt_add && !evt_remove) |=> !st_q.pres_chg);
  p_no_stray_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(st_q.link_chg) |-> $past(clr_link_chg));
  p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_ok && clr_pres_chg) |=> st_q.pres_chg);
  p_dup_add_r10: assert property (@(posedge clk) disable iff (rst)
    (evt_add && st_q.present) |=> st_q.present);
  p_both_r10: assert property (@(posedge clk) disable iff (rst)
    (evt_add && evt_remove) |=> $stable(st_q.present));
endmodule

// File: rtl/slot_hp_irq.sv
module slot_hp_irq
  import slot_hp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  slot_ctl_t ctl,
  input  slot_st_t  st,
  input  logic      ev_ok,
  output logic      msi_req
);
  logic hp_ie_d, pending, replay, ev_fire;

  assign pending = (st.pres_chg & ctl.pres_en) | (st.link_chg & ctl.dll_en);
  assign replay  = ctl.hp_ie & ~hp_ie_d & pending;
  assign ev_fire = ev_ok & ctl.hp_ie & (ctl.pres_en | ctl.dll_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      hp_ie_d <= 1'b0;
      msi_req <= 1'b0;
    end else begin
      hp_ie_d <= ctl.hp_ie;
      msi_req <= ev_fire | replay;
    end
  end

  p_msi_gated_r3: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> $past(ctl.hp_ie));
  p_msi_cause_r9: assert property (@(posedge clk) disable iff (rst)
    msi_req |-> ($past(ev_ok) || !$past(hp_ie_d)));
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int CAP_BASE = 'h40,
  parameter int SLOT_NUM = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              evt_add,
  input  logic              evt_remove,
  output logic              msi_req
);
  slot_ctl_t ctl;
  slot_st_t  st;
  logic clr_pres_chg, clr_link_chg, ev_ok;

  slot_hp_cfg #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .SLOT_NUM(SLOT_NUM)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .addr(cfg_addr),
    .be(cfg_be), .wdata(cfg_wdata), .st(st), .ctl(ctl),
    .clr_pres_chg(clr_pres_chg), .clr_link_chg(clr_link_chg), .rdata(cfg_rdata));

  slot_hp_state u_state (
    .clk(clk), .rst(rst), .evt_add(evt_add), .evt_remove(evt_remove),
    .clr_pres_chg(clr_pres_chg), .clr_link_chg(clr_link_chg), .st(st), .ev_ok(ev_ok));

  slot_hp_irq u_irq (
    .clk(clk), .rst(rst), .ctl(ctl), .st(st), .ev_ok(ev_ok), .msi_req(msi_req));

  p_cc_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_rd_en) && ($past(cfg_addr) == ADDR_W'((CAP_BASE + 24) / 4))) |-> !cfg_rdata[ST_CC]);
endmodule

// File: tb/sim_slot_hp_ctrl.sv
module sim_slot_hp_ctrl;
  localparam int ADDR_W = 10;
  localparam int CAP_BASE = 'h40;
  localparam int SLOT_NUM = 37;
  localparam logic [ADDR_W-1:0] A_LNK = ADDR_W'((CAP_BASE + 16) / 4);
  localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'((CAP_BASE + 20) / 4);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'((CAP_BASE + 24) / 4);

  logic clk = 0, rst = 1;
  logic wr_en = 0, rd_en = 0, evt_add = 0, evt_remove = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0, rdata;
  logic msi_req;
  int vectors = 0, errors = 0;
  logic occ = 0;

  slot_hp_ctrl #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE), .SLOT_NUM(SLOT_NUM)) u0 (
    .clk(clk), .rst(rst), .cfg_wr_en(wr_en), .cfg_rd_en(rd_en), .cfg_addr(addr),
    .cfg_be(be), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .evt_add(evt_add), .evt_remove(evt_remove), .msi_req(msi_req));

  always #10 clk = ~clk;

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic chk(input logic ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [3:0] b, input logic [31:0] d);
    wr_en = 1; addr = a; be = b; wdata = d; tick; wr_en = 0; be = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; tick; rd_en = 0; d = rdata;
  endtask

  task automatic ev(input logic a, input logic r);
    evt_add = a; evt_remove = r; tick; evt_add = 0; evt_remove = 0;
  endtask

  function automatic logic [31:0] ctl_bits(input logic [3:0] c);
    return (32'(c[0]) << 3) | (32'(c[1]) << 4) | (32'(c[2]) << 5) | (32'(c[3]) << 12);
  endfunction

  function automatic logic [31:0] cs_word(input logic [3:0] c, input logic pdc, input logic pds, input logic dsc);
    return ctl_bits(c) | (32'(pdc) << 19) | (32'(pds) << 22) | (32'(dsc) << 24);
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, e;
    tick; tick; rst = 0; tick;

    // R11 reset state and unmapped read
    chk(msi_req == 0, "R11 msi", 32'(msi_req), 0);
    rd(A_CTL, d); chk(d == 0, "R11 ctl/status", d, 0);
    rd(A_LNK, d); chk(d == 0, "R11 link", d, 0);
    rd('0, d);    chk(d == 0, "R11 unmapped", d, 0);
    // R6 capabilities
    e = (32'(SLOT_NUM) << 19) | (32'd1 << 18) | (32'd1 << 6) | (32'd1 << 5);
    rd(A_CAP, d); chk(d == e, "R6 caps", d, e);

    // R1 R2 R3 R10 sweep: enables x occupancy x event pattern
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 4; k++) begin
          logic acc, exp_msi, nocc;
          wr(A_CTL, 4'h3, 32'h0);
          if (occ != s[0]) begin ev(~occ, occ); occ = s[0]; end
          wr(A_CTL, 4'hC, (32'd1 << 19) | (32'd1 << 24));
          wr(A_CTL, 4'h3, ctl_bits(4'(c)));
          tick;
          acc = (k == 1 && !occ) || (k == 2 && occ);
          nocc = acc ? ~occ : occ;
          exp_msi = acc && c[2] && (c[0] || c[3]);
          ev(k[0], k[1]);
          chk(msi_req == exp_msi, "R3 msi on event", 32'(msi_req), 32'(exp_msi));
          tick;
          chk(msi_req == 0, "R3 single cycle", 32'(msi_req), 0);
          e = cs_word(4'(c), acc, nocc, acc);
          rd(A_CTL, d); chk(d == e, acc ? (nocc ? "R1 add status" : "R2 remove status") : "R10 ignored", d, e);
          e = 32'(nocc) << 29;
          rd(A_LNK, d); chk(d == e, "R1 R2 link active", d, e);
          occ = nocc;
        end
      end
    end

    // R4 write-1-to-clear with lanes
    wr(A_CTL, 4'h3, 32'h0);
    ev(~occ, occ); occ = ~occ;
    wr(A_CTL, 4'h3, 32'hFFFF_FFFF & ~32'h38 & ~32'h1000);
    rd(A_CTL, d); e = cs_word(4'h0, 1, occ, 1); chk(d == e, "R4 lane off no clear", d, e);
    wr(A_CTL, 4'hC, 32'h0);
    rd(A_CTL, d); chk(d == e, "R4 write zero", d, e);
    wr(A_CTL, 4'h4, 32'hFFFF_0000);
    rd(A_CTL, d); e = cs_word(4'h0, 0, occ, 1); chk(d == e, "R4 clear pres chg", d, e);
    wr(A_CTL, 4'h8, 32'hFFFF_0000);
    rd(A_CTL, d); e = cs_word(4'h0, 0, occ, 0); chk(d == e, "R4 clear link chg", d, e);

    // R8 read-only presence and link
    wr(A_CTL, 4'h4, 32'h0040_0000 ^ (32'(occ) << 22));
    wr(A_LNK, 4'h8, 32'h2000_0000 ^ (32'(occ) << 29));
    rd(A_CTL, d); e = cs_word(4'h0, 0, occ, 0); chk(d == e, "R8 presence ro", d, e);
    rd(A_LNK, d); e = 32'(occ) << 29; chk(d == e, "R8 link ro", d, e);

    // R7 control storage, lanes, completion bit
    wr(A_CTL, 4'h1, 32'hFFFF_FFFF);
    rd(A_CTL, d); e = ctl_bits(4'h7); chk(d == e, "R7 lane0 only", d, e);
    chk(msi_req == 0, "R7 no completion msi", 32'(msi_req), 0);
    wr(A_CTL, 4'h2, 32'hFFFF_FFFF);
    rd(A_CTL, d); e = ctl_bits(4'hF); chk(d == e, "R7 lane1 and CC zero", d, e);
    chk(msi_req == 0, "R7 no msi", 32'(msi_req), 0);

    // R5 event against same-cycle clear
    wr(A_CTL, 4'h3, 32'h0);
    wr_en = 1; addr = A_CTL; be = 4'hC; wdata = (32'd1 << 19) | (32'd1 << 24);
    evt_add = ~occ; evt_remove = occ; tick;
    wr_en = 0; be = 0; evt_add = 0; evt_remove = 0; occ = ~occ;
    rd(A_CTL, d); e = cs_word(4'h0, 1, occ, 1); chk(d == e, "R5 event wins", d, e);

    // R9 replay with pending presence change
    wr(A_CTL, 4'h3, 32'h28);
    chk(msi_req == 0, "R9 not yet", 32'(msi_req), 0);
    tick; chk(msi_req == 1, "R9 replay", 32'(msi_req), 1);
    tick; chk(msi_req == 0, "R9 one pulse", 32'(msi_req), 0);
    wr(A_CTL, 4'h3, 32'h28); tick;
    chk(msi_req == 0, "R9 already enabled", 32'(msi_req), 0);
    wr(A_CTL, 4'h3, 32'h0);
    wr(A_CTL, 4'h3, 32'h1020); tick;
    chk(msi_req == 1, "R9 replay link chg", 32'(msi_req), 1);
    wr(A_CTL, 4'h3, 32'h0);
    wr(A_CTL, 4'h3, 32'h20); tick;
    chk(msi_req == 0, "R9 no enabled source", 32'(msi_req), 0);
    wr(A_CTL, 4'h3, 32'h0);
    wr(A_CTL, 4'hC, (32'd1 << 19) | (32'd1 << 24));
    wr(A_CTL, 4'h3, 32'h1028); tick;
    chk(msi_req == 0, "R9 nothing pending", 32'(msi_req), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule